// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the array address for a synchronous burst cache RAM. Either of two active-low strobes can open an access: one driven by the processor, one by the cache controller. On that edge the block registers the full external address. The two least significant bits seed a 2-bit wraparound burst counter. After that, an active-low advance input steps the low bits through a four-beat sequence, or holds them where they are. A mode pin picks the sequence: linear (modulo-4 increment) or interleaved (start value XOR beat number).

Three chip enables qualify a new access: enable 1 active low, enable 2 active high and enable 3 active low. The processor strobe is gated by enable 1. If both strobes are low on the same edge, the processor strobe wins. When a strobe is seen but the enables do not all agree, the block deselects itself. Cycles without a strobe continue or suspend the current burst whatever the enables are doing. The outputs are the registered array address and a flag that marks a selected, valid access.

Top module: `burst_addr_gen`

## Requirements
- R1: Synchronous active-high reset clears `sel_valid` to 0 and `addr_out` to 0. This holds even in the middle of a burst.
- R2: A strobe is effective when `proc_strb_n` is low with `ce1_n` low, or when `ctrl_strb_n` is low. If a strobe is effective and `ce1_n`=0, `ce2`=1, `ce3_n`=0, then after that edge `addr_out` equals `addr_in` and `sel_valid` is 1.
- R3: With both strobes low and all enables active, exactly one capture of `addr_in` takes place. Its result is the same as a processor-strobe capture.
- R4: While `ce1_n` is high, `proc_strb_n` has no effect. With `ctrl_strb_n` high the cycle acts as a continue or suspend cycle. With `ctrl_strb_n` low the controller strobe alone decides the cycle.
- R5: An effective strobe while any chip enable is inactive clears `sel_valid` on the next edge and leaves `addr_out` unchanged.
- R6: With `mode_ilv`=1, beat k of a burst starting at low bits s has low bits s XOR k. For example, start 01 gives 01, 00, 11, 10.
- R7: With `mode_ilv`=0, beat k has low bits (s + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R8: With no effective strobe and `adv_n` high, `addr_out` and `sel_valid` keep their values.
- R9: Stepping changes only `addr_out[1:0]`. The upper bits stay as captured, with no carry into them. After four advances the address is back at the start value.
- R10: Continue cycles (no effective strobe, `adv_n` low) advance the burst whatever the values of `ce1_n`, `ce2` and `ce3_n`.
- R11: While `sel_valid` is 0, a low `adv_n` without a strobe leaves `addr_out` and `sel_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_out | output | ADDR_W | Registered array address |
| sel_valid | output | 1 | Registered selected/valid flag |

## Verification
Every result is due one clock edge after its inputs are sampled. Both outputs come straight from registers that update on the edge where the strobe, enables, advance and mode are seen. The bench changes inputs on the falling edge and checks the outputs 1 ns after the next rising edge. Each check therefore sees exactly one edge's effect. Sequences of several beats, such as the wrap and the interleave order, are checked one beat per cycle against values worked out from the starting address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_DESEL = 3'd2,
    OP_STEP  = 3'd3,
    OP_HOLD  = 3'd4
  } burst_op_t;
endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      proc_strb_n,
  input  logic      ctrl_strb_n,
  input  logic      adv_n,
  input  logic      ce1_n,
  input  logic      ce2,
  input  logic      ce3_n,
  input  logic      active,
  output burst_op_t op
);
  logic proc_hit;
  logic ctrl_hit;
  logic enables_ok;

  assign proc_hit   = !proc_strb_n && !ce1_n;
  assign ctrl_hit   = !ctrl_strb_n;
  assign enables_ok = !ce1_n && ce2 && !ce3_n;

  // Processor strobe takes priority; controller strobe is considered only without it.
  always_comb begin
    if (proc_hit) begin
      op = enables_ok ? OP_LOAD : OP_DESEL;
    end else if (ctrl_hit) begin
      op = enables_ok ? OP_LOAD : OP_DESEL;
    end else if (!active) begin
      op = OP_IDLE;
    end else if (!adv_n) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;
    end
  end

  // R4: with enable 1 high and no controller strobe, nothing opens or closes an access
  p_ce1_gates_proc_r4: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && ctrl_strb_n) |-> (op != OP_LOAD && op != OP_DESEL));

  // R10: no strobe and advance low on an active burst always steps
  p_continue_any_ce_r10: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && ctrl_strb_n && !adv_n && active) |-> (op == OP_STEP));
endmodule

// File: rtl/burst_step_counter.sv
module burst_step_counter
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  burst_op_t        op,
  input  logic [CNT_W-1:0] start_lo,
  input  logic             mode_ilv,
  output logic [CNT_W-1:0] next_lo
);
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] beat_q;
  logic [CNT_W-1:0] beat_nx;

  assign beat_nx = beat_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (op == OP_LOAD) begin
      base_q <= start_lo;
      beat_q <= '0;
    end else if (op == OP_STEP) begin
      beat_q <= beat_nx;
    end
  end

  // Order chosen per cycle from the sampled mode pin.
  always_comb begin
    if (mode_ilv) next_lo = base_q ^ beat_nx;
    else          next_lo = base_q + beat_nx;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              mode_ilv,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel_valid
);
  localparam int LO_W = 2;
  localparam int HI_W = ADDR_W - LO_W;

  burst_op_t       op;
  logic [LO_W-1:0] next_lo;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            valid_q;

  burst_strobe_decode u_dec (
    .clk         (clk),
    .rst         (rst),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .adv_n       (adv_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .active      (valid_q),
    .op          (op)
  );

  burst_step_counter #(.CNT_W(LO_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .start_lo (addr_in[LO_W-1:0]),
    .mode_ilv (mode_ilv),
    .next_lo  (next_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      case (op)
        OP_LOAD: begin
          hi_q    <= addr_in[ADDR_W-1:LO_W];
          lo_q    <= addr_in[LO_W-1:0];
          valid_q <= 1'b1;
        end
        OP_DESEL: valid_q <= 1'b0;
        OP_STEP:  lo_q    <= next_lo;
        default:  ;
      endcase
    end
  end

  assign addr_out  = {hi_q, lo_q};
  assign sel_valid = valid_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!sel_valid && addr_out == '0));

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (sel_valid && addr_out == $past(addr_in)));

  p_desel_keeps_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |=> (!sel_valid && $stable(addr_out)));

  p_linear_step_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP && !mode_ilv) |=> (addr_out[LO_W-1:0] == $past(addr_out[LO_W-1:0]) + LO_W'(1)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> ($stable(addr_out) && $stable(sel_valid)));

  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP) |=> (addr_out[ADDR_W-1:LO_W] == $past(addr_out[ADDR_W-1:LO_W])));

  p_idle_inert_r11: assert property (@(posedge clk) disable iff (rst)
    (!sel_valid && proc_strb_n && ctrl_strb_n) |=> (!sel_valid && $stable(addr_out)));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_strb_n = 1'b1;
  logic          ctrl_strb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          ce1_n = 1'b0;
  logic          ce2 = 1'b1;
  logic          ce3_n = 1'b0;
  logic          mode_ilv = 1'b1;
  logic [AW-1:0] addr_out;
  logic          sel_valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode_ilv(mode_ilv),
    .addr_out(addr_out), .sel_valid(sel_valid)
  );

  // addr, ps_n, cs_n, adv_n, ce1_n, ce2, ce3_n, mode, exp_valid, exp_addr, tag
  typedef struct packed {
    logic [AW-1:0] a;
    logic ps, cs, adv, c1, c2, c3, md;
    logic ev;
    logic [AW-1:0] ea;
    logic [8*3-1:0] tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b1, 1'b0, 17'h00000, "R11"},
    '{17'h12345, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h12345, "R2 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h12344, "R6 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h12347, "R6 "},
    '{17'h00000, 1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h12347, "R8 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h12346, "R6 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h12345, "R9 "},
    '{17'h0ABCD, 1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0, 1'b0, 1'b1, 17'h0ABCD, "R2 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b0, 1'b1, 17'h0ABCE, "R7 "},
    '{17'h1FFFF, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 1'b0, 1'b1, 17'h0ABCF, "R4 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1, 1'b0, 1'b1, 17'h0ABCC, "R10"},
    '{17'h1FFFE, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0, 1'b0, 1'b1, 17'h1FFFE, "R3 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b0, 1'b1, 17'h1FFFF, "R7 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b0, 1'b1, 17'h1FFFC, "R9 "},
    '{17'h00010, 1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b0, 1'b0, 17'h1FFFC, "R5 "},
    '{17'h00000, 1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0, 1'b0, 1'b0, 17'h1FFFC, "R11"},
    '{17'h00007, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 1'b1, 1'b1, 17'h00007, "R2 "},
    '{17'h00000, 1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 1'b1, 1'b0, 17'h00007, "R4 "},
    '{17'h00004, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 1'b1, 1'b0, 17'h00007, "R4 "}
  };

  task automatic check(input string req, input logic ev, input logic [AW-1:0] ea);
    checks++;
    if (sel_valid !== ev || addr_out !== ea) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%05h, expected valid=%0b addr=%05h",
               req, sel_valid, addr_out, ev, ea);
    end
  endtask

  task automatic idle_inputs();
    addr_in = '0; proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b0, '0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr_in = VECS[i].a; proc_strb_n = VECS[i].ps; ctrl_strb_n = VECS[i].cs;
      adv_n = VECS[i].adv; ce1_n = VECS[i].c1; ce2 = VECS[i].c2;
      ce3_n = VECS[i].c3; mode_ilv = VECS[i].md;
      @(posedge clk); #1;
      check(string'(VECS[i].tag), VECS[i].ev, VECS[i].ea);
    end

    // R6: interleaved from start 10, a full lap, then R9 wrap
    @(negedge clk); idle_inputs(); mode_ilv = 1'b1; addr_in = 17'h0F0F2; proc_strb_n = 1'b0;
    @(posedge clk); #1 check("R2", 1'b1, 17'h0F0F2);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); idle_inputs(); adv_n = 1'b0;
      @(posedge clk); #1;
      check(k == 4 ? "R9" : "R6", 1'b1, {15'h3C3C, 2'b10 ^ 2'(k)});
    end

    // R1: reset in the middle of a burst
    @(negedge clk); idle_inputs(); adv_n = 1'b0; rst = 1'b1;
    @(posedge clk); #1 check("R1", 1'b0, '0);
    @(negedge clk); rst = 1'b0; idle_inputs(); adv_n = 1'b0;
    @(posedge clk); #1 check("R11", 1'b0, '0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule